// File: doc/BRIEF.md
# PCIe Link Rate Switch Sequencer

This block steers one PCIe transceiver channel, or a group of bonded channels, between the 2.5 Gbps (Gen1) and 5 Gbps (Gen2) signalling rates. The PHY-MAC layer drives a level-encoded rate select. When that level changes, the sequencer sends a rate command to the clock-switch circuitry. The circuitry itself sits outside this block and answers with a one-cycle completion strobe. From the start of the switch until that strobe arrives, the sequencer holds the transmit and receive phase-compensation FIFO pointers in reset. When the switch completes, it releases them and sends the PHY-MAC layer a single status-done pulse.

The transmitter pre-emphasis taps change together with the rate command. At Gen2 both taps are zero. At Gen1 they take two programmed configuration values. A receive digital reset that arrives while the link runs at Gen2 sends the link back to Gen1.

If the completion strobe does not arrive in time, a sticky timeout flag is raised and the FIFO pointers stay in reset until software clears the flag. A rate change that arrives in the middle of a sequence is remembered and carried out once the current sequence has finished.

Top module: `pcie_rate_switch`

## Requirements
- R1: After reset, rate_cmd_o is 0 (Gen1), fifo_rst_o is 0, phy_done_o is 0 and tmo_flag_o is 0.
- R2: A level change of rate_sel_i in either direction starts a switch. Three clock edges after the new level is presented, fifo_rst_o is 1 and rate_cmd_o equals the new level (0 = Gen1, 1 = Gen2). rate_cmd_o stays constant while fifo_rst_o is held.
- R3: A rate_sel_i level equal to the current rate starts no sequence. rx_dig_rst_i asserted while at Gen1 has no effect. In both cases fifo_rst_o stays 0 and no phy_done_o pulse occurs.
- R4: fifo_rst_o stays 1 until sw_done_i is sampled high. It is 0 from the next cycle on, in the same cycle as phy_done_o.
- R5: phy_done_o is a one-cycle pulse, given exactly once for each completed switch. It occurs only in the cycle after sw_done_i was sampled high.
- R6: rx_dig_rst_i asserted while idle at Gen2 starts a switch to Gen1, even though rate_sel_i stays high. The link then remains at Gen1 until rate_sel_i makes a further edge to 1.
- R7: The pre-emphasis outputs emph_pre_o and emph_post_o are both 0 while rate_cmd_o is 1 (Gen2). While rate_cmd_o is 0 (Gen1) they equal cfg_gen1_pre_i and cfg_gen1_post_i.
- R8: If sw_done_i does not arrive within tmo_limit_i cycles of the start of a switch, tmo_flag_o sets and stays set until tmo_clr_i. Meanwhile fifo_rst_o remains 1 and no phy_done_o occurs.
- R9: tmo_clr_i clears tmo_flag_o and releases fifo_rst_o. The unfinished rate change is then retried and completes normally.
- R10: A rate change that arrives during a sequence does not abort it. It is serviced afterwards, so the phy_done_o pulses report the rates in request order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel_i | input | 1 | Requested rate level from PHY-MAC (0 Gen1, 1 Gen2) |
| rx_dig_rst_i | input | 1 | Receive digital reset |
| sw_done_i | input | 1 | Clock-switch completion strobe |
| tmo_limit_i | input | CNTW | Completion timeout in cycles |
| tmo_clr_i | input | 1 | Clears the timeout flag |
| cfg_gen1_pre_i | input | TAPW | Gen1 pre-emphasis tap value |
| cfg_gen1_post_i | input | TAPW | Gen1 post-emphasis tap value |
| rate_cmd_o | output | 1 | Rate command to clock-switch circuitry |
| fifo_rst_o | output | 1 | Phase-compensation FIFO pointer reset/disable |
| phy_done_o | output | 1 | One-cycle switch-complete status pulse |
| tmo_flag_o | output | 1 | Sticky completion-timeout flag |
| emph_pre_o | output | TAPW | Pre-emphasis tap output |
| emph_post_o | output | TAPW | Post-emphasis tap output |

## Verification
The bench changes the requested rate in the middle of a switch and expects two status pulses in request order. A design that aborted the running sequence would drop one pulse, and one that lost the late request would never report the second rate. It sends a receive reset at Gen2 while the rate select stays high. A design that compared the current rate against the raw level would bounce straight back to Gen2 and produce an extra, unexpected pulse. It also withholds the completion strobe until the timeout fires. A design that released the FIFO reset on timeout, or pulsed done anyway, is caught there, as is one that failed to retry the switch after the flag was cleared.

// File: rtl/pcie_rsw_pkg.sv
package pcie_rsw_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_SWITCH = 2'd1,
    SEQ_HOLD   = 2'd2
  } seq_state_e;

  localparam logic RATE_GEN1 = 1'b0;
  localparam logic RATE_GEN2 = 1'b1;
endpackage

// File: rtl/rsw_req_track.sv
module rsw_req_track
  import pcie_rsw_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic rate_sel_i,
  input  logic rx_dig_rst_i,
  input  logic cur_rate_i,
  output logic want_o
);
  logic sel_q, sel_d1_q;
  logic want_q, want_d;
  logic sel_edge, force_gen1, want_en;

  assign sel_edge   = (sel_q != sel_d1_q);
  assign force_gen1 = rx_dig_rst_i && (cur_rate_i == RATE_GEN2);
  assign want_en    = sel_edge || force_gen1;

  always_comb begin
    want_d = want_q;
    if (sel_edge)   want_d = sel_q;
    if (force_gen1) want_d = RATE_GEN1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q    <= RATE_GEN1;
      sel_d1_q <= RATE_GEN1;
    end else begin
      sel_q    <= rate_sel_i;
      sel_d1_q <= sel_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       want_q <= RATE_GEN1;
    else if (want_en) want_q <= want_d;
  end

  assign want_o = want_q;

  // R6
  fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_dig_rst_i && cur_rate_i == RATE_GEN2) |=> (want_o == RATE_GEN1));
endmodule

// File: rtl/rsw_seq_fsm.sv
module rsw_seq_fsm
  import pcie_rsw_pkg::*;
#(
  parameter int CNTW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            want_i,
  input  logic            sw_done_i,
  input  logic [CNTW-1:0] tmo_limit_i,
  input  logic            tmo_clr_i,
  output logic            cur_rate_o,
  output logic            rate_cmd_o,
  output logic            fifo_rst_o,
  output logic            done_o,
  output logic            tmo_flag_o
);
  localparam logic [CNTW-1:0] CNT_ONE = CNTW'(1);

  seq_state_e      state_q, state_d;
  logic            cmd_q, cmd_d;
  logic            cur_q, cur_d;
  logic            done_q, done_d;
  logic            flag_q, flag_d;
  logic [CNTW-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cmd_d   = cmd_q;
    cur_d   = cur_q;
    done_d  = 1'b0;
    flag_d  = flag_q;
    cnt_d   = cnt_q;
    case (state_q)
      SEQ_IDLE: begin
        if (want_i != cur_q) begin
          state_d = SEQ_SWITCH;
          cmd_d   = want_i;
          cnt_d   = '0;
        end
      end
      SEQ_SWITCH: begin
        if (sw_done_i) begin
          state_d = SEQ_IDLE;
          cur_d   = cmd_q;
          done_d  = 1'b1;
        end else if (cnt_q >= tmo_limit_i) begin
          state_d = SEQ_HOLD;
          flag_d  = 1'b1;
        end else begin
          cnt_d = cnt_q + CNT_ONE;
        end
      end
      SEQ_HOLD: begin
        if (tmo_clr_i) begin
          state_d = SEQ_IDLE;
          flag_d  = 1'b0;
          cmd_d   = cur_q;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      cmd_q   <= RATE_GEN1;
      cur_q   <= RATE_GEN1;
      done_q  <= 1'b0;
      flag_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cmd_q   <= cmd_d;
      cur_q   <= cur_d;
      done_q  <= done_d;
      flag_q  <= flag_d;
      cnt_q   <= cnt_d;
    end
  end

  assign cur_rate_o = cur_q;
  assign rate_cmd_o = cmd_q;
  assign fifo_rst_o = (state_q != SEQ_IDLE);
  assign done_o     = done_q;
  assign tmo_flag_o = flag_q;

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(sw_done_i));
  // R4
  fifo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rst_o && !sw_done_i && !tmo_clr_i) |=> fifo_rst_o);
  // R2
  cmd_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_rst_o && $past(fifo_rst_o)) |-> $stable(rate_cmd_o));
  // R8
  tmo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag_o && !tmo_clr_i) |=> tmo_flag_o);
  // R8
  tmo_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tmo_flag_o && !tmo_clr_i) |=> !done_o);
endmodule

// File: rtl/rsw_tap_sel.sv
module rsw_tap_sel #(
  parameter int TAPW = 5,
  parameter int NTAP = 2
) (
  input  logic                      rate_cmd_i,
  input  logic [NTAP-1:0][TAPW-1:0] gen1_taps_i,
  output logic [NTAP-1:0][TAPW-1:0] taps_o
);
  for (genvar t = 0; t < NTAP; t++) begin : g_tap
    assign taps_o[t] = rate_cmd_i ? '0 : gen1_taps_i[t];
  end
endmodule

// File: rtl/pcie_rate_switch.sv
module pcie_rate_switch #(
  parameter int CNTW = 16,
  parameter int TAPW = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rate_sel_i,
  input  logic            rx_dig_rst_i,
  input  logic            sw_done_i,
  input  logic [CNTW-1:0] tmo_limit_i,
  input  logic            tmo_clr_i,
  input  logic [TAPW-1:0] cfg_gen1_pre_i,
  input  logic [TAPW-1:0] cfg_gen1_post_i,
  output logic            rate_cmd_o,
  output logic            fifo_rst_o,
  output logic            phy_done_o,
  output logic            tmo_flag_o,
  output logic [TAPW-1:0] emph_pre_o,
  output logic [TAPW-1:0] emph_post_o
);
  localparam int NTAP = 2;

  logic want, cur_rate;
  logic [NTAP-1:0][TAPW-1:0] gen1_taps, taps;

  assign gen1_taps[0] = cfg_gen1_pre_i;
  assign gen1_taps[1] = cfg_gen1_post_i;
  assign emph_pre_o   = taps[0];
  assign emph_post_o  = taps[1];

  rsw_req_track u_req (
    .clk          (clk),
    .rst_n        (rst_n),
    .rate_sel_i   (rate_sel_i),
    .rx_dig_rst_i (rx_dig_rst_i),
    .cur_rate_i   (cur_rate),
    .want_o       (want)
  );

  rsw_seq_fsm #(.CNTW(CNTW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .want_i      (want),
    .sw_done_i   (sw_done_i),
    .tmo_limit_i (tmo_limit_i),
    .tmo_clr_i   (tmo_clr_i),
    .cur_rate_o  (cur_rate),
    .rate_cmd_o  (rate_cmd_o),
    .fifo_rst_o  (fifo_rst_o),
    .done_o      (phy_done_o),
    .tmo_flag_o  (tmo_flag_o)
  );

  rsw_tap_sel #(.TAPW(TAPW), .NTAP(NTAP)) u_tap (
    .rate_cmd_i  (rate_cmd_o),
    .gen1_taps_i (gen1_taps),
    .taps_o      (taps)
  );
endmodule

// File: tb/pcie_rate_switch_test.sv
module pcie_rate_switch_test;
  localparam int CNTW = 16;
  localparam int TAPW = 5;
  localparam logic [TAPW-1:0] PRE_G1  = 5'h0B;
  localparam logic [TAPW-1:0] POST_G1 = 5'h03;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rate_sel_i = 1'b0;
  logic rx_dig_rst_i = 1'b0;
  logic sw_done_i;
  logic [CNTW-1:0] tmo_limit_i = 16'd200;
  logic tmo_clr_i = 1'b0;
  logic rate_cmd_o, fifo_rst_o, phy_done_o, tmo_flag_o;
  logic [TAPW-1:0] emph_pre_o, emph_post_o;

  int checks = 0;
  int fails = 0;
  int done_cnt = 0;
  logic exp_q[$];
  logic resp_en = 1'b1;
  int resp_delay = 6;
  int resp_cnt = 0;
  logic prev_done = 1'b0;

  always #10 clk = ~clk;

  pcie_rate_switch #(.CNTW(CNTW), .TAPW(TAPW)) uut (
    .clk(clk), .rst_n(rst_n), .rate_sel_i(rate_sel_i),
    .rx_dig_rst_i(rx_dig_rst_i), .sw_done_i(sw_done_i),
    .tmo_limit_i(tmo_limit_i), .tmo_clr_i(tmo_clr_i),
    .cfg_gen1_pre_i(PRE_G1), .cfg_gen1_post_i(POST_G1),
    .rate_cmd_o(rate_cmd_o), .fifo_rst_o(fifo_rst_o),
    .phy_done_o(phy_done_o), .tmo_flag_o(tmo_flag_o),
    .emph_pre_o(emph_pre_o), .emph_post_o(emph_post_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
  endtask

  // clock-switch circuitry model
  initial begin
    sw_done_i = 1'b0;
    forever begin
      @(negedge clk);
      sw_done_i = 1'b0;
      if (resp_en && fifo_rst_o && !tmo_flag_o) begin
        if (resp_cnt == resp_delay) begin
          sw_done_i = 1'b1;
          resp_cnt = 0;
        end else resp_cnt++;
      end else resp_cnt = 0;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n) begin
      if (phy_done_o) begin
        done_cnt++;
        check("R4 fifo released with done", int'(fifo_rst_o), 0);
        check("R5 done single cycle", int'(prev_done), 0);
        if (exp_q.size() == 0) begin
          check("R5 unexpected done", 1, 0);
        end else begin
          automatic logic e = exp_q.pop_front();
          check("R10 completed rate order", int'(rate_cmd_o), int'(e));
          check("R7 pre tap at done", int'(emph_pre_o), e ? 0 : int'(PRE_G1));
          check("R7 post tap at done", int'(emph_post_o), e ? 0 : int'(POST_G1));
        end
      end
      prev_done = phy_done_o;
    end
  end

  task automatic request(input logic r);
    @(negedge clk);
    rate_sel_i = r;
    exp_q.push_back(r);
  endtask

  task automatic wait_done(input int target, input string req);
    int n = 0;
    while (done_cnt < target && n < 400) begin
      @(negedge clk);
      #1;
      n++;
    end
    check(req, done_cnt, target);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1, 0);
    summary();
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    // R1 reset state
    check("R1 rate_cmd", int'(rate_cmd_o), 0);
    check("R1 fifo_rst", int'(fifo_rst_o), 0);
    check("R1 done", int'(phy_done_o), 0);
    check("R1 tmo_flag", int'(tmo_flag_o), 0);
    check("R7 gen1 pre at reset", int'(emph_pre_o), int'(PRE_G1));
    check("R7 gen1 post at reset", int'(emph_post_o), int'(POST_G1));

    // R3 rx reset at Gen1 and steady level do nothing
    @(negedge clk); rx_dig_rst_i = 1'b1;
    @(negedge clk); rx_dig_rst_i = 1'b0;
    idle(8);
    check("R3 no sequence fifo", int'(fifo_rst_o), 0);
    check("R3 no done", done_cnt, 0);

    // R2 rising edge to Gen2
    request(1'b1);
    idle(3);
    check("R2 fifo_rst asserted", int'(fifo_rst_o), 1);
    check("R2 rate_cmd gen2", int'(rate_cmd_o), 1);
    check("R7 gen2 pre zero", int'(emph_pre_o), 0);
    check("R7 gen2 post zero", int'(emph_post_o), 0);
    idle(3);
    check("R4 fifo held before switch done", int'(fifo_rst_o), 1);
    wait_done(1, "R5 done after gen2 switch");

    // R10 change mid-sequence: to Gen1 then back to Gen2
    resp_delay = 10;
    request(1'b0);
    idle(7);
    check("R2 falling edge starts switch", int'(fifo_rst_o), 1);
    request(1'b1);
    wait_done(3, "R10 both requests serviced");
    idle(4);
    check("R10 final rate gen2", int'(rate_cmd_o), 1);
    check("R10 idle after both", int'(fifo_rst_o), 0);

    // R6 receive reset at Gen2 falls back to Gen1
    resp_delay = 4;
    @(negedge clk); rx_dig_rst_i = 1'b1; exp_q.push_back(1'b0);
    @(negedge clk); rx_dig_rst_i = 1'b0;
    wait_done(4, "R6 fallback done");
    idle(10);
    check("R6 stays gen1", int'(rate_cmd_o), 0);
    check("R6 no bounce", int'(fifo_rst_o), 0);
    @(negedge clk); rate_sel_i = 1'b0;
    idle(8);
    check("R3 level equal to rate", int'(fifo_rst_o), 0);
    request(1'b1);
    wait_done(5, "R6 new edge returns to gen2");

    // R8 timeout, R9 clear and retry
    resp_en = 1'b0;
    tmo_limit_i = 16'd20;
    request(1'b0);
    idle(10);
    check("R8 flag not yet", int'(tmo_flag_o), 0);
    idle(30);
    check("R8 flag set", int'(tmo_flag_o), 1);
    check("R8 fifo held on timeout", int'(fifo_rst_o), 1);
    check("R8 no done on timeout", done_cnt, 5);
    idle(5);
    check("R8 flag sticky", int'(tmo_flag_o), 1);
    resp_en = 1'b1;
    tmo_clr_i = 1'b1;
    @(negedge clk);
    tmo_clr_i = 1'b0;
    check("R9 flag cleared", int'(tmo_flag_o), 0);
    check("R9 fifo released", int'(fifo_rst_o), 0);
    wait_done(6, "R9 retry completes");
    idle(3);
    check("R9 rate gen1", int'(rate_cmd_o), 0);
    check("R7 gen1 pre restored", int'(emph_pre_o), int'(PRE_G1));
    check("R5 all expected dones seen", exp_q.size(), 0);

    summary();
    $finish;
  end
endmodule